// File: doc/BRIEF.md
# Third-Order Sinc Decimator for a One-Bit Modulator Stream

This block turns a one-bit delta-sigma bitstream into 16-bit conversion words. It runs on the modulator clock, which is its only clock. The bit input is captured on every rising edge, because the modulator moves its data on the falling edge. Three integrators fold each captured bit (a one counts as 1, a zero as 0) into running sums at the modulator rate. Once every decimation period, three differencing stages turn the last integrator's value into a raw sinc³ result. That result is re-centred so that half density reads zero, then scaled so that every ratio shares one 16-bit full scale. The word can be presented as two's complement or as offset binary.

The oversampling ratio is chosen at run time from 16, 32, 64, 128 or 256. A synchronous reset, or any change of the effective ratio, flushes the filter. A small settling state machine then tracks how many words have come out since the flush:

- ST_WARM1 moves to ST_WARM2 on the first word.
- ST_WARM2 moves to ST_WARM3 on the second word.
- ST_WARM3 moves to ST_LOCKED on the third word.
- ST_LOCKED holds until the next flush.
- A flush from any state returns the machine to ST_WARM1.

The settled flag is raised together with the third word, which is the first word whose impulse-response window lies wholly inside post-flush samples.

Top module: `sinc3_decimator`

## Requirements
- R1: While reset is sampled high on a rising edge, the next cycle shows `word_valid` 0, `settled` 0 and `word_out` 0.
- R2: `word_valid` is a single-cycle pulse. Consecutive pulses are exactly OSR clocks apart, where OSR = 16 << `osr_sel` for codes 0 to 4.
- R3: `osr_sel` codes 5, 6 and 7 act as code 4 (OSR 256). Switching between any two of the codes 4 to 7 neither flushes the filter nor disturbs the word spacing.
- R4: For a steady periodic stream whose period divides OSR, a settled signed word equals ones_fraction·65536 − 32768 at every ratio. So 50 % gives 0, 87.5 % gives 24576, 12.5 % gives −24576 and 25 % gives −16384.
- R5: The signed word saturates at 32767 for an all-ones stream and reads −32768 for an all-zeros stream.
- R6: With `offset_fmt` = 1, bit 15 of the signed word is inverted, so 0 reads 0x8000 (offset binary).
- R7: After a flush, the first two words carry `settled` = 0. The third word and every later word carry `settled` = 1.
- R8: A change of the effective ratio discards that cycle's sample, produces no word in that cycle and clears `settled`. The first word under the new ratio appears exactly OSR clocks after the change edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mod_clk | input | 1 | Modulator clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset (flush) |
| mod_bit | input | 1 | Modulator bitstream, changes on the falling edge |
| osr_sel | input | 3 | Ratio code: OSR = 16 << code, codes above 4 mean 256 |
| offset_fmt | input | 1 | 1 selects offset-binary output, 0 two's complement |
| word_out | output | 16 | Scaled conversion word |
| word_valid | output | 1 | One-cycle strobe marking a new word |
| settled | output | 1 | High while words are fully settled |

## Verification
The checker watches several timing rules on every cycle. It checks the exact spacing of the valid pulses, including spacing that restarts after a ratio change and is unaffected by aliased codes. It also checks the one-cycle pulse width, the unsettled/settled pattern of the first three words after a flush, and the clearing of the flag on a ratio change. The numeric word values can only be shown by the bench's scenarios, which drive known ones densities at several ratios and in both output codings: mid-scale, the 87.5 % and 12.5 % points, 25 %, the saturating all-ones stream and the all-zeros stream.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

    // Settling tracker: number of words seen since the last flush
    typedef enum logic [1:0] {
        ST_WARM1  = 2'd0,
        ST_WARM2  = 2'd1,
        ST_WARM3  = 2'd2,
        ST_LOCKED = 2'd3
    } settle_state_e;

endpackage

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl
    import sinc3_pkg::*;
#(
    parameter int OSR_LOG2_MIN = 4,
    parameter int OSR_LOG2_MAX = 8,
    parameter int SEL_W        = 3,
    parameter int LW           = $clog2(OSR_LOG2_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] osr_sel,
    output logic             clr,
    output logic             tick,
    output logic             settle_word,
    output logic [LW-1:0]    osr_log2
);

    localparam int NCODES = OSR_LOG2_MAX - OSR_LOG2_MIN + 1;
    localparam logic [SEL_W-1:0] MAX_CODE = SEL_W'(NCODES - 1);
    localparam int CNT_W = OSR_LOG2_MAX;

    logic [SEL_W-1:0] sel_clamp;
    logic [SEL_W-1:0] sel_q;
    logic             ratio_change;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_last;

    settle_state_e state_q;
    settle_state_e state_nx;

    // Out-of-range codes alias onto the largest ratio
    assign sel_clamp    = (osr_sel > MAX_CODE) ? MAX_CODE : osr_sel;
    assign ratio_change = (sel_clamp != sel_q);
    assign clr          = rst | ratio_change;
    assign osr_log2     = LW'(OSR_LOG2_MIN) + LW'(sel_q);
    assign cnt_last     = CNT_W'((32'd1 << osr_log2) - 32'd1);
    assign tick         = !clr && (cnt_q == cnt_last);

    always_ff @(posedge clk) begin
        if (clr) begin
            sel_q <= sel_clamp;
        end
    end

    // Decimation phase counter
    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (clr) begin
            state_q <= ST_WARM1;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_WARM1:  if (tick) state_nx = ST_WARM2;
            ST_WARM2:  if (tick) state_nx = ST_WARM3;
            ST_WARM3:  if (tick) state_nx = ST_LOCKED;
            ST_LOCKED: state_nx = ST_LOCKED;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        settle_word = 1'b0;
        unique case (state_q)
            ST_WARM1:  settle_word = 1'b0;
            ST_WARM2:  settle_word = 1'b0;
            ST_WARM3:  settle_word = 1'b1;
            ST_LOCKED: settle_word = 1'b1;
        endcase
    end

endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
    parameter int ACC_W = 25,
    parameter int ORDER = 3
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             din,
    output logic [ACC_W-1:0] sum_next
);

    logic [ACC_W-1:0] nxt [ORDER];

    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        logic [ACC_W-1:0] acc_q;

        if (g == 0) begin : g_first
            assign nxt[g] = acc_q + ACC_W'(din);
        end else begin : g_chain
            assign nxt[g] = acc_q + nxt[g-1];
        end

        // Wraparound accumulation; the final result always fits ACC_W
        always_ff @(posedge clk) begin
            if (clr) begin
                acc_q <= '0;
            end else begin
                acc_q <= nxt[g];
            end
        end
    end

    assign sum_next = nxt[ORDER-1];

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
    parameter int ACC_W = 25,
    parameter int ORDER = 3
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             tick,
    input  logic [ACC_W-1:0] din,
    output logic [ACC_W-1:0] dout
);

    logic [ACC_W-1:0] diff [ORDER];

    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        logic [ACC_W-1:0] dly_q;
        logic [ACC_W-1:0] stage_in;

        if (g == 0) begin : g_first
            assign stage_in = din;
        end else begin : g_chain
            assign stage_in = diff[g-1];
        end

        assign diff[g] = stage_in - dly_q;

        always_ff @(posedge clk) begin
            if (clr) begin
                dly_q <= '0;
            end else if (tick) begin
                dly_q <= stage_in;
            end
        end
    end

    assign dout = diff[ORDER-1];

endmodule

// File: rtl/sinc3_scale.sv
module sinc3_scale #(
    parameter int ACC_W        = 25,
    parameter int OUT_W        = 16,
    parameter int ORDER        = 3,
    parameter int OSR_LOG2_MAX = 8,
    parameter int LW           = $clog2(OSR_LOG2_MAX + 1)
) (
    input  logic [ACC_W-1:0] raw,
    input  logic [LW-1:0]    osr_log2,
    input  logic             offset_fmt,
    output logic [OUT_W-1:0] word
);

    localparam int SW = $clog2(ORDER * OSR_LOG2_MAX + 1);
    localparam int WW = ACC_W + OUT_W;

    logic [SW-1:0]        gain_log2;
    logic [ACC_W-1:0]     half_scale;
    logic [ACC_W-1:0]     centered;
    logic signed [WW-1:0] wide;
    logic                 pos_ovf;
    logic                 neg_ovf;
    logic [OUT_W-1:0]     sword;

    always_comb begin
        // Raw gain is OSR^ORDER; remove half of it so 50 % density is zero
        gain_log2  = SW'(ORDER) * SW'(osr_log2);
        half_scale = ACC_W'(1) << (gain_log2 - SW'(1));
        centered   = raw - half_scale;
        // Multiply by 2^OUT_W and divide by the raw gain
        wide       = signed'({centered, {OUT_W{1'b0}}}) >>> gain_log2;
        pos_ovf    = !wide[WW-1] && (|wide[WW-2:OUT_W-1]);
        neg_ovf    = wide[WW-1] && !(&wide[WW-2:OUT_W-1]);
        if (pos_ovf) begin
            sword = {1'b0, {(OUT_W-1){1'b1}}};
        end else if (neg_ovf) begin
            sword = {1'b1, {(OUT_W-1){1'b0}}};
        end else begin
            sword = wide[OUT_W-1:0];
        end
        word = offset_fmt ? {~sword[OUT_W-1], sword[OUT_W-2:0]} : sword;
    end

endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator #(
    parameter int OSR_LOG2_MIN = 4,
    parameter int OSR_LOG2_MAX = 8,
    parameter int OUT_W        = 16,
    parameter int ORDER        = 3,
    parameter int SEL_W        = 3
) (
    input  logic             mod_clk,
    input  logic             rst,
    input  logic             mod_bit,
    input  logic [SEL_W-1:0] osr_sel,
    input  logic             offset_fmt,
    output logic [OUT_W-1:0] word_out,
    output logic             word_valid,
    output logic             settled
);

    localparam int ACC_W = ORDER * OSR_LOG2_MAX + 1;
    localparam int LW    = $clog2(OSR_LOG2_MAX + 1);

    logic             clr;
    logic             tick;
    logic             settle_word;
    logic [LW-1:0]    osr_log2;
    logic [ACC_W-1:0] integ_sum;
    logic [ACC_W-1:0] comb_out;
    logic [OUT_W-1:0] scaled;

    sinc3_ctrl #(
        .OSR_LOG2_MIN(OSR_LOG2_MIN),
        .OSR_LOG2_MAX(OSR_LOG2_MAX),
        .SEL_W       (SEL_W),
        .LW          (LW)
    ) u_ctrl (
        .clk        (mod_clk),
        .rst        (rst),
        .osr_sel    (osr_sel),
        .clr        (clr),
        .tick       (tick),
        .settle_word(settle_word),
        .osr_log2   (osr_log2)
    );

    sinc3_integ #(
        .ACC_W(ACC_W),
        .ORDER(ORDER)
    ) u_integ (
        .clk     (mod_clk),
        .clr     (clr),
        .din     (mod_bit),
        .sum_next(integ_sum)
    );

    sinc3_comb #(
        .ACC_W(ACC_W),
        .ORDER(ORDER)
    ) u_comb (
        .clk (mod_clk),
        .clr (clr),
        .tick(tick),
        .din (integ_sum),
        .dout(comb_out)
    );

    sinc3_scale #(
        .ACC_W       (ACC_W),
        .OUT_W       (OUT_W),
        .ORDER       (ORDER),
        .OSR_LOG2_MAX(OSR_LOG2_MAX),
        .LW          (LW)
    ) u_scale (
        .raw       (comb_out),
        .osr_log2  (osr_log2),
        .offset_fmt(offset_fmt),
        .word      (scaled)
    );

    always_ff @(posedge mod_clk) begin
        if (clr) begin
            word_out   <= '0;
            word_valid <= 1'b0;
            settled    <= 1'b0;
        end else begin
            word_valid <= tick;
            if (tick) begin
                word_out <= scaled;
                settled  <= settle_word;
            end
        end
    end

endmodule

// File: rtl/sinc3_decimator_chk.sv
module sinc3_decimator_chk #(
    parameter int OSR_LOG2_MIN = 4,
    parameter int OSR_LOG2_MAX = 8,
    parameter int SEL_W        = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [SEL_W-1:0] osr_sel,
    input logic             word_valid,
    input logic             settled
);

    localparam int NCODES = OSR_LOG2_MAX - OSR_LOG2_MIN + 1;
    localparam logic [SEL_W-1:0] TOP_CODE = SEL_W'(NCODES - 1);
    localparam int GW = OSR_LOG2_MAX + 2;

    logic [SEL_W-1:0] sel_eff;
    logic [SEL_W-1:0] sel_seen;
    logic             sel_moved;
    logic [GW-1:0]    gap_cnt;
    logic [GW-1:0]    osr_expect;
    logic [1:0]       words_since;
    logic             rst_seen = 1'b0;

    assign sel_eff    = (osr_sel > TOP_CODE) ? TOP_CODE : osr_sel;
    assign sel_moved  = (sel_eff != sel_seen);
    assign osr_expect = GW'(1) << (OSR_LOG2_MIN + int'(sel_seen));

    always_ff @(posedge clk) begin
        rst_seen <= rst;
        if (rst || sel_moved) begin
            sel_seen    <= sel_eff;
            gap_cnt     <= '0;
            words_since <= '0;
        end else begin
            gap_cnt <= word_valid ? GW'(1) : gap_cnt + GW'(1);
            if (word_valid && words_since != 2'd3) begin
                words_since <= words_since + 2'd1;
            end
        end
    end

    always @(posedge clk) begin
        if (rst_seen) begin
            AST_RESET_QUIET: assert (!word_valid && !settled); // R1
        end
    end

    AST_WORD_SPACING: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> gap_cnt == osr_expect); // R2

    AST_ALIAS_SPACING: assert property (@(posedge clk) disable iff (rst)
        (word_valid && sel_seen == TOP_CODE) |-> gap_cnt == osr_expect); // R3

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid); // R2

    AST_EARLY_UNSETTLED: assert property (@(posedge clk) disable iff (rst)
        (word_valid && words_since < 2'd2) |-> !settled); // R7

    AST_LATE_SETTLED: assert property (@(posedge clk) disable iff (rst)
        (word_valid && words_since >= 2'd2) |-> settled); // R7

    AST_SETTLE_WITH_WORD: assert property (@(posedge clk) disable iff (rst)
        $rose(settled) |-> word_valid); // R7

    AST_CHANGE_FLUSH: assert property (@(posedge clk) disable iff (rst)
        sel_moved |=> (!settled && !word_valid)); // R8

endmodule

bind sinc3_decimator sinc3_decimator_chk #(
    .OSR_LOG2_MIN(OSR_LOG2_MIN),
    .OSR_LOG2_MAX(OSR_LOG2_MAX),
    .SEL_W       (SEL_W)
) u_chk (
    .clk       (mod_clk),
    .rst       (rst),
    .osr_sel   (osr_sel),
    .word_valid(word_valid),
    .settled   (settled)
);

// File: tb/sinc3_decimator_tb.sv
`timescale 1ns/1ps
module sinc3_decimator_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mod_bit = 1'b0;
    logic [2:0]  osr_sel = 3'd0;
    logic        offset_fmt = 1'b0;
    logic [15:0] word_out;
    logic        word_valid;
    logic        settled;

    always #2 clk = ~clk;

    sinc3_decimator u_dut (
        .mod_clk   (clk),
        .rst       (rst),
        .mod_bit   (mod_bit),
        .osr_sel   (osr_sel),
        .offset_fmt(offset_fmt),
        .word_out  (word_out),
        .word_valid(word_valid),
        .settled   (settled)
    );

    typedef struct {
        int    val;
        bit    chk_val;
        bit    stl;
        int    osr;
        bit    first;
        string req;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    int    start_cyc = 0;
    int    last_cyc = 0;
    int    words_seen = 0;
    logic [7:0] pat = 8'b0101_0101;
    int    ph = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Stream driver: the bit changes on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            mod_bit = pat[ph];
            ph = (ph + 1) % 8;
        end
    end

    // Monitor: pops the scoreboard on each word
    initial begin
        forever begin
            @(negedge clk);
            if (word_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R2", "unexpected word", 1, 0);
                end else begin
                    item_t it;
                    int gap;
                    it  = q.pop_front();
                    gap = it.first ? (cyc - start_cyc) : (cyc - last_cyc);
                    check(gap == it.osr, it.first ? "R8" : "R2", "word spacing",
                          gap, it.osr);
                    check(settled == it.stl, "R7", "settled flag",
                          int'(settled), int'(it.stl));
                    if (it.chk_val) begin
                        check(word_out == it.val[15:0], it.req, "word value",
                              int'(word_out), it.val & 16'hFFFF);
                    end
                end
                last_cyc = cyc;
                words_seen++;
            end
        end
    end

    // mode 0: reset restart, 1: ratio-change restart, 2: continue
    task automatic run_seg(input int mode, input logic [2:0] sel,
                           input logic [7:0] p, input bit off,
                           input int n_unset, input int n_set, input string req);
        int osr;
        int sv;
        int ev;
        int target;
        osr = 16 << ((sel > 3'd4) ? 4 : int'(sel));
        sv  = $countones(p) * 8192 - 32768;
        if (sv > 32767) sv = 32767;
        ev  = off ? ((sv + 32768) & 16'hFFFF) : (sv & 16'hFFFF);
        for (int i = 0; i < n_unset + n_set; i++) begin
            item_t it;
            it.val     = ev;
            it.chk_val = (i >= n_unset);
            it.stl     = (i >= n_unset);
            it.osr     = osr;
            it.first   = (i == 0) && (mode != 2);
            it.req     = req;
            q.push_back(it);
        end
        target = words_seen + n_unset + n_set;
        @(negedge clk);
        osr_sel    = sel;
        offset_fmt = off;
        if (mode != 2) pat = p;
        if (mode == 0) begin
            rst = 1'b1;
            @(negedge clk);
            rst = 1'b0;
            start_cyc = cyc;
            check(!word_valid && !settled && word_out == 16'd0, "R1",
                  "state after reset", int'(settled), 0);
        end else if (mode == 1) begin
            @(negedge clk);
            start_cyc = cyc;
            check(!word_valid && !settled, "R8", "flag after ratio change",
                  int'(settled), 0);
        end
        while (words_seen < target) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!word_valid && !settled && word_out == 16'd0, "R1",
              "initial reset outputs", int'(word_out), 0);
        run_seg(0, 3'd0, 8'b0101_0101, 1'b0, 2, 3, "R4");
        run_seg(1, 3'd1, 8'b1111_1110, 1'b0, 2, 3, "R4");
        run_seg(1, 3'd2, 8'b0001_0000, 1'b0, 2, 3, "R4");
        run_seg(0, 3'd3, 8'b1111_1111, 1'b0, 2, 2, "R5");
        run_seg(1, 3'd0, 8'b0000_0000, 1'b0, 2, 3, "R5");
        run_seg(0, 3'd1, 8'b1000_1000, 1'b1, 2, 3, "R6");
        run_seg(1, 3'd4, 8'b0111_1111, 1'b0, 2, 2, "R4");
        run_seg(2, 3'd7, 8'b0111_1111, 1'b0, 0, 2, "R3");
        run_seg(0, 3'd5, 8'b0011_0011, 1'b1, 2, 1, "R3");
        repeat (4) @(negedge clk);
        check(q.size() == 0, "R2", "words outstanding", q.size(), 0);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule